// File: doc/BRIEF.md
# Saturating Digital Wiper Controller

This block is the control section of a 100-position digitally set resistor tap. A host drives three asynchronous control lines: an active-low select, a direction level and a step strobe. While select is low, each falling edge of the step strobe moves a 7-bit wiper position one place up or down. The position saturates at 0 and at 99 instead of wrapping. The position is decoded into a 100-bit tap-select word. When the wiper moves, the outgoing and incoming taps are both driven for a short overlap window, so the path is made before it is broken.

A retained register stands in for the non-volatile cell. When select is released while the step strobe is high, the position is copied into that register and a timed store-busy phase follows. When select is released while the strobe is low, the position stays in effect but is not saved. After a reset, which stands for a power cycle, the wiper stays dark until the supply is reported stable. The saved position is then reloaded. A standby flag is high whenever the block is deselected and no store is running.

Top module: `wiper_ctrl`

## Requirements
- R1: After reset and until `supply_ok` is seen high, `pos_valid` is 0, `tap_sel` is all zeros, and step pulses have no effect.
- R2: On the first clock with `supply_ok` high after reset, the position is loaded from the retained register and `pos_valid` rises. The retained register is not cleared by reset and starts at `NV_INIT` (default 0).
- R3: With `sel_n` low, each high-to-low transition of `step_n` moves the position by +1 when `dir_up` is 1 and by -1 when `dir_up` is 0. The move shows on `wiper_pos` three clock edges after the strobe falls, because of a two-stage synchronizer and a registered update.
- R4: The position stays in 0..99. A step up at 99 leaves it at 99, and a step down at 0 leaves it at 0.
- R5: While `sel_n` is high, step pulses do not change the position.
- R6: When no overlap window is active, exactly one bit of `tap_sel` is 1, and it is bit `wiper_pos`.
- R7: On every move, the bits for the old and the new position are both 1 for `OVL_CYC` cycles, starting with the cycle in which the position changes. After that, only the new bit remains.
- R8: A rise of `sel_n` while `step_n` is high copies the position into the retained register. It also holds `store_busy` high for exactly `STORE_CYC` cycles, starting two edges after the rise is synchronized.
- R9: A rise of `sel_n` while `step_n` is low stores nothing and starts no busy phase. The position stays as it is, and a later reset recalls the earlier saved value.
- R10: `standby` is 1 when the position is valid, the synchronized select is high and no store is busy, and 0 otherwise.
- R11: While `store_busy` is high, step pulses are ignored even if `sel_n` is low.
- R12: The direction may change while `sel_n` stays low, and later steps in the same session follow the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, stands for power removal |
| supply_ok | input | 1 | Supply reported stable; gates the recall |
| sel_n | input | 1 | Active-low select (asynchronous) |
| dir_up | input | 1 | Step direction: 1 up, 0 down (asynchronous) |
| step_n | input | 1 | Step strobe, acts on its falling edge (asynchronous) |
| wiper_pos | output | 7 | Current wiper position, 0..99 |
| pos_valid | output | 1 | Position has been recalled and is in effect |
| tap_sel | output | 100 | Decoded tap selects, bit i for position i |
| store_busy | output | 1 | Save to the retained register in progress |
| standby | output | 1 | Deselected and idle |

## Verification
Several properties are checked on every clock: the position stays in range, it never moves by more than one place per cycle, and it is frozen while deselected or while a store runs. The tap word holds at most two set bits, and exactly one outside an overlap window. A store copies the position of the preceding cycle. Other behaviour can only be shown by bench scenarios: the exact busy length, the choice between storing and not storing on release, recall of the retained value across a reset, saturation after long step runs, and the placement of the overlap bits.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Move a position by one place, held inside 0..last.
  function automatic int unsigned clamp_step(int unsigned cur, logic up, int unsigned last);
    if (up) return (cur >= last) ? last : cur + 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Limit a recalled value to the legal range.
  function automatic int unsigned clamp_top(int unsigned v, int unsigned last);
    return (v > last) ? last : v;
  endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
  import wiper_pkg::*;
#(
  parameter int TAPS  = 100,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             step_ev,
  input  logic             up,
  input  logic [POS_W-1:0] recall_val,
  output logic [POS_W-1:0] pos,
  output logic             valid,
  output logic             move_now
);
  localparam int unsigned LAST = TAPS - 1;

  logic [POS_W-1:0] pos_q, nxt_pos, rec_pos;
  logic             valid_q;

  assign nxt_pos  = POS_W'(clamp_step(32'(pos_q), up, LAST));
  assign rec_pos  = POS_W'(clamp_top(32'(recall_val), LAST));
  assign move_now = valid_q && step_ev && (nxt_pos != pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      if (supply_ok) begin
        pos_q   <= rec_pos;
        valid_q <= 1'b1;
      end
    end else if (move_now) begin
      pos_q <= nxt_pos;
    end
  end

  assign pos   = pos_q;
  assign valid = valid_q;

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (pos_q <= POS_W'(LAST)));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q)) |->
      ((pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + POS_W'(1)) ||
       (pos_q + POS_W'(1) == $past(pos_q))));
endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int POS_W     = 7,
  parameter int STORE_CYC = 2000000,
  parameter logic [POS_W-1:0] NV_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_store,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nv_val,
  output logic             busy
);
  localparam int CNT_W = $clog2(STORE_CYC + 1);

  // Retained across reset: only a store writes it.
  logic [POS_W-1:0] nv_q = NV_INIT;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (go_store) nv_q <= pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (go_store)       cnt_q <= CNT_W'(STORE_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy   = (cnt_q != '0);
  assign nv_val = nv_q;

  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(go_store) |-> busy);
endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int TAPS    = 100,
  parameter int POS_W   = 7,
  parameter int OVL_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [POS_W-1:0] pos,
  input  logic             move_now,
  output logic [TAPS-1:0]  tap_sel
);
  logic             ovl_on;
  logic [POS_W-1:0] old_pos;

  generate
    if (OVL_CYC > 0) begin : g_ovl
      localparam int OW = $clog2(OVL_CYC + 1);
      logic [OW-1:0]    ovl_q;
      logic [POS_W-1:0] old_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ovl_q <= '0;
          old_q <= '0;
        end else if (move_now) begin
          ovl_q <= OW'(OVL_CYC);
          old_q <= pos;
        end else if (ovl_q != '0) begin
          ovl_q <= ovl_q - OW'(1);
        end
      end
      assign ovl_on  = (ovl_q != '0);
      assign old_pos = old_q;
    end else begin : g_no_ovl
      assign ovl_on  = 1'b0;
      assign old_pos = '0;
    end
  endgenerate

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = valid && ((pos == POS_W'(i)) || (ovl_on && (old_pos == POS_W'(i))));
  end

  a_r6_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ovl_on) |-> ($countones(tap_sel) == 1));

  a_r7_two_max: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) <= 2);
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int TAPS      = 100,
  parameter int STORE_CYC = 2000000,
  parameter int OVL_CYC   = 3,
  parameter int NV_INIT   = 0,
  localparam int POS_W    = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             sel_n,
  input  logic             dir_up,
  input  logic             step_n,
  output logic [POS_W-1:0] wiper_pos,
  output logic             pos_valid,
  output logic [TAPS-1:0]  tap_sel,
  output logic             store_busy,
  output logic             standby
);
  logic [2:0]       sync_q;
  logic             sel_s, dir_s, step_s;
  logic             sel_prev, step_prev;
  logic             step_ev, sel_rise, store_go, move_now;
  logic [POS_W-1:0] nv_val;

  wiper_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({sel_n, dir_up, step_n}),
    .q_sync(sync_q)
  );
  assign {sel_s, dir_s, step_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev  <= 1'b1;
      step_prev <= 1'b1;
    end else begin
      sel_prev  <= sel_s;
      step_prev <= step_s;
    end
  end

  // Named events for the assertions and the sub-blocks.
  assign step_ev  = step_prev && !step_s && !sel_s && !store_busy;
  assign sel_rise = sel_s && !sel_prev;
  assign store_go = sel_rise && step_s && pos_valid && !store_busy;

  wiper_counter #(.TAPS(TAPS), .POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .step_ev(step_ev), .up(dir_s), .recall_val(nv_val),
    .pos(wiper_pos), .valid(pos_valid), .move_now(move_now)
  );

  wiper_store #(.POS_W(POS_W), .STORE_CYC(STORE_CYC),
                .NV_INIT(POS_W'(NV_INIT))) u_store (
    .clk(clk), .rst_n(rst_n), .go_store(store_go),
    .pos(wiper_pos), .nv_val(nv_val), .busy(store_busy)
  );

  wiper_decode #(.TAPS(TAPS), .POS_W(POS_W), .OVL_CYC(OVL_CYC)) u_dec (
    .clk(clk), .rst_n(rst_n), .valid(pos_valid),
    .pos(wiper_pos), .move_now(move_now), .tap_sel(tap_sel)
  );

  assign standby = pos_valid && sel_s && !store_busy;

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_s) && $past(pos_valid)) |-> $stable(wiper_pos));

  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(store_busy) && $past(pos_valid)) |-> $stable(wiper_pos));

  a_r8_store_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_busy) |-> (nv_val == $past(wiper_pos)));

  a_r2_recall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_valid) |-> (wiper_pos == nv_val));

  a_r1_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_valid |-> (tap_sel == '0 && !standby));
endmodule

// File: tb/wiper_ctrl_tb_top.sv
module wiper_ctrl_tb_top;
  localparam int STORE = 40;
  localparam int OVL   = 3;

  logic clk = 1'b0;
  logic rst_n, supply_ok, sel_n, dir_up, step_n;
  logic [6:0]  wiper_pos;
  logic        pos_valid, store_busy, standby;
  logic [99:0] tap_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  wiper_ctrl #(.TAPS(100), .STORE_CYC(STORE), .OVL_CYC(OVL), .NV_INIT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sel_n(sel_n),
    .dir_up(dir_up), .step_n(step_n), .wiper_pos(wiper_pos),
    .pos_valid(pos_valid), .tap_sel(tap_sel), .store_busy(store_busy),
    .standby(standby)
  );

  // {dir, step count, expected position after the run}
  localparam logic [15:0] VEC [5] = '{
    {1'b1, 8'd5,   7'd5},
    {1'b0, 8'd2,   7'd3},
    {1'b0, 8'd10,  7'd0},
    {1'b1, 8'd120, 7'd99},
    {1'b0, 8'd49,  7'd50}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse();
    @(negedge clk) step_n = 1'b0;
    tick(4);
    @(negedge clk) step_n = 1'b1;
    tick(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int tap_ok(input int p);
    return (tap_sel[p] && $countones(tap_sel) == 1) ? 1 : 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; supply_ok = 0; sel_n = 1; dir_up = 1; step_n = 1;
    tick(5);
    @(negedge clk) rst_n = 1;
    tick(3);
    // R1: dark before supply, steps ignored
    chk("R1 valid", pos_valid, 0);
    @(negedge clk) sel_n = 0;
    pulse();
    chk("R1 tap", (tap_sel == '0) ? 1 : 0, 1);
    chk("R10 standby dark", standby, 0);
    @(negedge clk) sel_n = 1;
    tick(4);
    @(negedge clk) supply_ok = 1;
    tick(2);
    chk("R2 valid", pos_valid, 1);
    chk("R2 recall", wiper_pos, 0);
    chk("R6 tap0", tap_ok(0), 1);
    chk("R10 standby idle", standby, 1);

    // R3, R4, R12: table of step runs in one session
    @(negedge clk) sel_n = 0;
    tick(4);
    chk("R10 selected", standby, 0);
    for (int v = 0; v < 5; v++) begin
      @(negedge clk) dir_up = VEC[v][15];
      for (int k = 0; k < int'(VEC[v][14:7]); k++) pulse();
      chk("R3/R4/R12 run", wiper_pos, int'(VEC[v][6:0]));
    end
    chk("R6 tap50", tap_ok(50), 1);

    // R7: overlap on 50 -> 51
    @(negedge clk) begin dir_up = 1; step_n = 1'b0; end
    tick(3);
    chk("R3 timing", wiper_pos, 51);
    chk("R7 two bits", $countones(tap_sel), 2);
    chk("R7 old and new", (tap_sel[50] && tap_sel[51]) ? 1 : 0, 1);
    tick(OVL - 1);
    chk("R7 still overlapping", $countones(tap_sel), 2);
    tick(1);
    chk("R7 after window", tap_ok(51), 1);
    @(negedge clk) step_n = 1'b1;
    tick(4);

    // R8: store on release with strobe high
    @(negedge clk) sel_n = 1;
    tick(3);
    chk("R8 busy", store_busy, 1);
    chk("R10 busy standby", standby, 0);
    begin
      int n = 0;
      while (store_busy && n < 1000) begin tick(1); n++; end
      chk("R8 busy length", n, STORE);
    end
    chk("R10 standby after store", standby, 1);

    // R5: deselected steps ignored
    pulse();
    pulse();
    chk("R5 hold", wiper_pos, 51);

    // R11: steps during busy ignored
    @(negedge clk) sel_n = 0;
    tick(4);
    @(negedge clk) dir_up = 0;
    pulse();
    chk("R12 down", wiper_pos, 50);
    @(negedge clk) sel_n = 1;
    tick(3);
    chk("R8 second busy", store_busy, 1);
    @(negedge clk) begin sel_n = 0; dir_up = 1; end
    pulse();
    pulse();
    chk("R11 frozen", wiper_pos, 50);
    chk("R11 still busy", store_busy, 1);
    tick(STORE);
    chk("R8 busy done", store_busy, 0);
    pulse();
    chk("R11 resumes", wiper_pos, 51);

    // R9: release with strobe low, no store
    @(negedge clk) step_n = 1'b0;
    tick(4);
    @(negedge clk) sel_n = 1;
    tick(4);
    @(negedge clk) step_n = 1'b1;
    tick(4);
    chk("R9 no busy", store_busy, 0);
    chk("R9 pos kept", wiper_pos, 52);
    chk("R10 standby no store", standby, 1);

    // R9, R2: power cycle recalls last saved value (50)
    @(negedge clk) begin rst_n = 0; supply_ok = 0; end
    tick(3);
    @(negedge clk) rst_n = 1;
    tick(3);
    chk("R1 after cycle", pos_valid, 0);
    @(negedge clk) supply_ok = 1;
    tick(2);
    chk("R9 recall saved", wiper_pos, 50);
    chk("R6 tap recalled", tap_ok(50), 1);

    // R4: clamp at top again from the recalled value
    @(negedge clk) begin sel_n = 0; dir_up = 1; end
    tick(4);
    for (int k = 0; k < 52; k++) pulse();
    chk("R4 top clamp", wiper_pos, 99);
    chk("R6 tap99", tap_ok(99), 1);

    finish_run();
  end
endmodule